// File: doc/BRIEF.md
# Transport Packet Output Formatter

This block sits at the end of a terrestrial receive chain. It takes decoded transport packets one byte at a time, together with a flag that marks bytes the error decoder could not repair, and presents each packet to a downstream transport processor. The output is either an 8-bit parallel bus or a 1-bit serial stream that is carried on one line of that bus. Three strobes go with the data: packet start, data valid, and an active-low block error that covers the whole packet. A packet that fails decoding can have the error-indicator bit in its header forced high. The output can be set to change on the falling clock edge, so that it is stable at the rising edge. An output-enable pin idles all outputs.

The input uses a valid/ready handshake. A byte moves when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high only while the internal single-packet store still has room. Once the store holds a complete packet, `in_ready` stays low until the last output unit of that packet has been presented. While `in_ready` is low, the source must hold `in_valid`, `in_data` and `in_bad` steady. Output pacing is not generated here. `out_tick` is the per-unit enable at the output rate: one byte per tick in parallel mode, one bit per tick in serial mode.

Top module: `tsf_out_formatter`

## Requirements
- R1: A byte is accepted when `in_valid` and `in_ready` are both high at a rising edge, and every PKT_LEN accepted bytes form one packet. `in_ready` is low from the edge that accepts a packet's last byte until that packet's last output unit has been presented. Bytes held at the input during that time are accepted later, with none lost.
- R2: In parallel mode (`serial_mode`=0, sampled at the packet's first tick), a packet occupies exactly PKT_LEN consecutive ticks. The ticks carry one byte each, in the order the bytes were accepted, on `out_data[7:0]`.
- R3: In serial mode (`serial_mode`=1), each byte is sent most significant bit first over 8 ticks, so a packet spans 8·PKT_LEN ticks. The bit appears on `out_data[0]` when `serial_swap`=0 and on `out_data[7]` when `serial_swap`=1, and the other seven lines stay 0. Both mode pins are sampled at the packet's first tick.
- R4: `out_start` is high for the first byte of a packet only: 1 tick in parallel mode, 8 ticks in serial mode.
- R5: `out_valid` rises with the first unit of a packet and stays high without a break through its last unit.
- R6: `out_err_n` is low for every unit of a packet if any of its bytes was accepted with `in_bad` high. Otherwise it is high for the whole packet.
- R7: Byte index 1 (the second byte), bit 7, is the error-indicator bit. It is output as 1 when `tei_en`=1 and the packet is bad. In every other case the byte passes through unchanged.
- R8: Between packets, `out_data` is 0, `out_start` and `out_valid` are 0, and `out_err_n` is 1.
- R9: While `oe_n` is high, the outputs show the gap values of R8 whatever the packet state is. The packet is still consumed internally.
- R10: With `fall_edge`=1, the outputs change only at falling clock edges. With `fall_edge`=0, they change only at rising edges.
- R11: A clock edge at which `out_tick` is low changes no output.
- R12: After reset, the outputs show gap values and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Store can take a byte |
| in_data | input | 8 | Input byte |
| in_bad | input | 1 | Byte belongs to an uncorrectable packet |
| out_tick | input | 1 | Output unit enable (byte or bit rate) |
| serial_mode | input | 1 | 1 = serial output, 0 = parallel |
| serial_swap | input | 1 | Serial line: 0 = bit 0, 1 = bit 7 |
| fall_edge | input | 1 | 1 = outputs change on falling edge |
| tei_en | input | 1 | Force the header error bit on bad packets |
| oe_n | input | 1 | Output enable, active low |
| out_data | output | 8 | Output data bus |
| out_start | output | 1 | First byte of packet |
| out_valid | output | 1 | Packet data present |
| out_err_n | output | 1 | Packet uncorrectable, active low |

## Verification
The bench builds the block with its default PKT_LEN of 188. This means full-length packets are sent, including the 1504-tick serial span and the header byte at index 1. With the true packet length, the valid-span and start-width counts are checked against the real frame size rather than a shortened stand-in. The run covers both output edges, both serial lines, a half-rate tick and back-to-back packets that stall the input.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int TSF_BYTE_W = 8;
  localparam int TSF_BIT_W  = $clog2(TSF_BYTE_W);
  // header error-indicator location (downstream decodes it here)
  localparam int TSF_TEI_BYTE = 1;
  localparam int TSF_TEI_BIT  = 7;

  typedef struct packed {
    logic [TSF_BYTE_W-1:0] data;
    logic                  start;
    logic                  valid;
    logic                  err_n;
  } tsf_pins_t;

  localparam tsf_pins_t TSF_IDLE = '{data: '0, start: 1'b0, valid: 1'b0, err_n: 1'b1};
endpackage

// File: rtl/tsf_pkt_buf.sv
module tsf_pkt_buf
  import tsf_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [TSF_BYTE_W-1:0]   in_data,
  input  logic                    in_bad,
  input  logic                    rel,
  input  logic [$clog2(PKT_LEN)-1:0] rd_idx,
  output logic [TSF_BYTE_W-1:0]   rd_byte,
  output logic                    full,
  output logic                    bad
);
  localparam int IW = $clog2(PKT_LEN);
  localparam int CW = $clog2(PKT_LEN + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(PKT_LEN);

  logic [TSF_BYTE_W-1:0] mem [PKT_LEN];
  logic [CW-1:0]         count;
  logic                  bad_q;
  logic                  take;

  assign full     = (count == FULL_CNT);
  assign in_ready = !full;
  assign take     = in_valid && in_ready;
  assign bad      = bad_q;
  assign rd_byte  = mem[rd_idx];

  // fill counter and sticky packet error flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      bad_q <= 1'b0;
    end else if (rel) begin
      count <= '0;
      bad_q <= 1'b0;
    end else if (take) begin
      count <= count + 1'b1;
      bad_q <= bad_q | in_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[count[IW-1:0]] <= in_data;
  end
endmodule

// File: rtl/tsf_emit.sv
module tsf_emit
  import tsf_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       full,
  input  logic                       bad,
  input  logic [TSF_BYTE_W-1:0]      rd_byte,
  input  logic                       serial_mode,
  input  logic                       serial_swap,
  input  logic                       tei_en,
  output logic [$clog2(PKT_LEN)-1:0] rd_idx,
  output logic                       rel,
  output tsf_pins_t                  core
);
  localparam int IW = $clog2(PKT_LEN);
  localparam logic [IW-1:0]        LAST_IDX = IW'(PKT_LEN - 1);
  localparam logic [IW-1:0]        TEI_IDX  = IW'(TSF_TEI_BYTE);
  localparam logic [TSF_BIT_W-1:0] LAST_BIT = TSF_BIT_W'(TSF_BYTE_W - 1);

  logic [IW-1:0]         idx;
  logic [TSF_BIT_W-1:0]  bitc;
  logic                  ser_q, swp_q;
  logic                  first_unit, ser_now, swp_now, last_unit, sbit;
  logic [TSF_BYTE_W-1:0] hdr, unit_data;
  tsf_pins_t             core_q;

  always_comb begin
    first_unit = (idx == '0) && (bitc == '0);
    ser_now    = first_unit ? serial_mode : ser_q;
    swp_now    = first_unit ? serial_swap : swp_q;
    hdr        = rd_byte;
    if (idx == TEI_IDX && tei_en && bad) hdr[TSF_TEI_BIT] = 1'b1;
    sbit       = hdr[LAST_BIT - bitc];
    unit_data  = '0;
    if (!ser_now)     unit_data = hdr;
    else if (swp_now) unit_data[TSF_BYTE_W-1] = sbit;
    else              unit_data[0] = sbit;
    last_unit  = (idx == LAST_IDX) && (!ser_now || bitc == LAST_BIT);
  end

  assign rel    = tick && full && last_unit;
  assign rd_idx = idx;
  assign core   = core_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      bitc   <= '0;
      ser_q  <= 1'b0;
      swp_q  <= 1'b0;
      core_q <= TSF_IDLE;
    end else if (tick) begin
      if (full) begin
        core_q.data  <= unit_data;
        core_q.start <= (idx == '0);
        core_q.valid <= 1'b1;
        core_q.err_n <= !bad;
        ser_q        <= ser_now;
        swp_q        <= swp_now;
        if (last_unit) begin
          idx  <= '0;
          bitc <= '0;
        end else if (ser_now && bitc != LAST_BIT) begin
          bitc <= bitc + 1'b1;
        end else begin
          idx  <= idx + 1'b1;
          bitc <= '0;
        end
      end else begin
        core_q <= TSF_IDLE;
      end
    end
  end
endmodule

// File: rtl/tsf_pin_stage.sv
module tsf_pin_stage
  import tsf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      oe_n,
  input  logic      fall_edge,
  input  tsf_pins_t core,
  output tsf_pins_t pins
);
  tsf_pins_t gated;
  tsf_pins_t fall_q;

  assign gated = oe_n ? TSF_IDLE : core;

  // half-cycle retime so the pins are settled at the next rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= TSF_IDLE;
    else        fall_q <= gated;
  end

  assign pins = fall_edge ? fall_q : gated;
endmodule

// File: rtl/tsf_out_formatter.sv
module tsf_out_formatter
  import tsf_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_bad,
  input  logic       out_tick,
  input  logic       serial_mode,
  input  logic       serial_swap,
  input  logic       fall_edge,
  input  logic       tei_en,
  input  logic       oe_n,
  output logic [7:0] out_data,
  output logic       out_start,
  output logic       out_valid,
  output logic       out_err_n
);
  localparam int IW = $clog2(PKT_LEN);

  logic                  full, bad, rel;
  logic [IW-1:0]         rd_idx;
  logic [TSF_BYTE_W-1:0] rd_byte;
  tsf_pins_t             core, pins;

  tsf_pkt_buf #(.PKT_LEN(PKT_LEN)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bad(in_bad), .rel(rel), .rd_idx(rd_idx),
    .rd_byte(rd_byte), .full(full), .bad(bad)
  );

  tsf_emit #(.PKT_LEN(PKT_LEN)) u_emit (
    .clk(clk), .rst_n(rst_n), .tick(out_tick), .full(full), .bad(bad),
    .rd_byte(rd_byte), .serial_mode(serial_mode), .serial_swap(serial_swap),
    .tei_en(tei_en), .rd_idx(rd_idx), .rel(rel), .core(core)
  );

  tsf_pin_stage u_pins (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .fall_edge(fall_edge),
    .core(core), .pins(pins)
  );

  assign out_data  = pins.data;
  assign out_start = pins.start;
  assign out_valid = pins.valid;
  assign out_err_n = pins.err_n;
endmodule

// File: rtl/tsf_out_formatter_chk.sv
module tsf_out_formatter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       out_tick,
  input logic       fall_edge,
  input logic       oe_n,
  input logic [7:0] out_data,
  input logic       out_start,
  input logic       out_valid,
  input logic       out_err_n
);
  a_r4_start_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);

  a_r6_err_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_err_n |-> out_valid);

  a_r8_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == 8'h00 && !out_start && out_err_n));

  a_r5_opens_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_start);

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_tick && !oe_n) |=> (oe_n || (fall_edge != $past(fall_edge)) ||
                              ($stable(out_data) && $stable(out_valid) && $stable(out_start))));
endmodule

bind tsf_out_formatter tsf_out_formatter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_tick(out_tick), .fall_edge(fall_edge), .oe_n(oe_n),
  .out_data(out_data), .out_start(out_start), .out_valid(out_valid), .out_err_n(out_err_n)
);

// File: tb/tsf_out_formatter_bench.sv
module tsf_out_formatter_bench;
  localparam int PL = 188;
  localparam logic [10:0] IDLE = 11'b00000000_001;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       in_valid = 0, in_ready, in_bad = 0;
  logic [7:0] in_data = 0;
  logic       out_tick = 0, serial_mode = 0, serial_swap = 0;
  logic       fall_edge = 1, tei_en = 1, oe_n = 0;
  logic [7:0] out_data;
  logic       out_start, out_valid, out_err_n;
  logic [10:0] pins;
  assign pins = {out_data, out_start, out_valid, out_err_n};

  tsf_out_formatter #(.PKT_LEN(PL)) u_tsf_out_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bad(in_bad), .out_tick(out_tick),
    .serial_mode(serial_mode), .serial_swap(serial_swap), .fall_edge(fall_edge),
    .tei_en(tei_en), .oe_n(oe_n), .out_data(out_data), .out_start(out_start),
    .out_valid(out_valid), .out_err_n(out_err_n)
  );

  int n_cmp = 0, n_bad = 0, mon_unit = 0;
  bit tick_alt = 0, oe_blank = 0;
  logic [7:0] exp_byte_q[$];
  bit exp_bad_q[$], exp_ser_q[$], exp_swp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] pkt_byte(input logic [7:0] seed, input int k, input bit msb);
    if (k == 0) return 8'h47;
    if (k == 1) return {msb, seed[6:0]};
    return 8'((k * 13) ^ seed ^ (k >> 2));
  endfunction

  // driver: pushes expectations, then offers bytes under back-pressure
  task automatic send_pkt(input logic [7:0] seed, input int bad_at, input bit msb, input bit expect_out);
    bit bad = (bad_at >= 0);
    if (expect_out) begin
      exp_bad_q.push_back(bad); exp_ser_q.push_back(serial_mode); exp_swp_q.push_back(serial_swap);
      for (int k = 0; k < PL; k++) begin
        logic [7:0] b = pkt_byte(seed, k, msb);
        if (k == 1 && tei_en && bad) b[7] = 1'b1;
        exp_byte_q.push_back(b);
      end
    end
    for (int k = 0; k < PL; k++) begin
      in_valid = 1; in_data = pkt_byte(seed, k, msb); in_bad = (k == bad_at);
      while (!in_ready) step;
      step;
    end
    in_valid = 0; in_bad = 0;
    chk(in_ready === 1'b0, "R1 stall after full packet", in_ready, 0);
  endtask

  task automatic wait_idle;
    while (exp_bad_q.size() != 0 || exp_byte_q.size() != 0 || mon_unit != 0) step;
    repeat (3) step;
  endtask

  // output pacing
  initial begin
    wait (rst_n);
    forever begin
      step;
      out_tick = tick_alt ? ~out_tick : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic [10:0] a, b, prev;
    logic [7:0] acc, eb;
    bit tk, cur_bad, cur_ser, cur_swp, v;
    prev = IDLE; acc = 0; cur_bad = 0; cur_ser = 0; cur_swp = 0;
    wait (rst_n);
    forever begin
      @(posedge clk); tk = out_tick;
      #2 a = pins;
      #4 b = pins;
      if (b !== prev)
        chk(fall_edge ? (a === prev) : (a === b), "R10 change edge", a, fall_edge ? prev : b);
      if (!tk) chk(b === prev, "R11 hold without tick", b, prev);
      else if (oe_blank) chk(b === IDLE, "R9 outputs idled", b, IDLE);
      else if (b[1]) begin
        if (mon_unit == 0) begin
          if (exp_bad_q.size() == 0) chk(0, "R2 unexpected packet", b, 0);
          else begin
            cur_bad = exp_bad_q.pop_front(); cur_ser = exp_ser_q.pop_front(); cur_swp = exp_swp_q.pop_front();
          end
        end
        chk(b[2] === (cur_ser ? (mon_unit < 8) : (mon_unit == 0)), "R4 start width", b[2], mon_unit);
        chk(b[0] === !cur_bad, "R6 block error", b[0], !cur_bad);
        if (!cur_ser) begin
          eb = (exp_byte_q.size() != 0) ? exp_byte_q.pop_front() : 8'h00;
          chk(b[10:3] === eb, (mon_unit == 1) ? "R7 header byte" : "R2 parallel byte", b[10:3], eb);
        end else begin
          v = cur_swp ? b[10] : b[3];
          chk(cur_swp ? (b[9:3] === 7'd0) : (b[10:4] === 7'd0), "R3 unused lines", b[10:3], 0);
          acc = {acc[6:0], v};
          if (mon_unit % 8 == 7) begin
            eb = (exp_byte_q.size() != 0) ? exp_byte_q.pop_front() : 8'h00;
            chk(acc === eb, (mon_unit / 8 == 1) ? "R7 header byte serial" : "R3 serial byte", acc, eb);
          end
        end
        mon_unit++;
      end else begin
        if (mon_unit != 0) begin
          chk(mon_unit == (cur_ser ? 8 * PL : PL), "R5 valid span", mon_unit, cur_ser ? 8 * PL : PL);
          mon_unit = 0;
        end
        chk(b === IDLE, "R8 gap values", b, IDLE);
      end
      prev = b;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R2 got=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step;
    rst_n = 1;
    step;
    chk(pins === IDLE, "R12 reset outputs", pins, IDLE);
    chk(in_ready === 1'b1, "R12 reset ready", in_ready, 1);
    // parallel, falling edge, back-to-back packets stall the input (R1)
    send_pkt(8'h11, -1, 0, 1);
    send_pkt(8'h22, 50, 0, 1);
    wait_idle;
    // rising edge, header bit passes through with forcing off
    fall_edge = 0; tei_en = 0;
    send_pkt(8'h33, 0, 0, 1);
    send_pkt(8'h44, -1, 1, 1);
    wait_idle;
    // half-rate ticks, error on the last byte
    tei_en = 1; tick_alt = 1;
    send_pkt(8'h55, PL - 1, 0, 1);
    wait_idle;
    tick_alt = 0;
    // serial on both lines
    serial_mode = 1; serial_swap = 0;
    send_pkt(8'h66, 3, 0, 1);
    wait_idle;
    serial_swap = 1; fall_edge = 1;
    send_pkt(8'h77, -1, 1, 1);
    wait_idle;
    serial_mode = 0;
    // outputs disabled for one whole packet, then recovery
    oe_n = 1; oe_blank = 1;
    send_pkt(8'h88, 5, 0, 0);
    while (!in_ready) step;
    repeat (4) step;
    oe_n = 0; oe_blank = 0;
    send_pkt(8'h99, -1, 0, 1);
    wait_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule